// File: doc/BRIEF.md
# Paged Audio Controller Register Interface

This block is the host-side register file of a three-channel audio controller with two playback channels and one record channel. A host reaches it through a 256-byte I/O window using byte, halfword or word accesses. It holds the control, status, page, codec and serial-control registers, a sample-count register for each channel, and a frame address and frame count register for each channel. The per-channel frame registers are reached only through a 4-bit page register, which is folded into the effective address.

Channel enables, sample formats and interrupt enables go straight to the channel datapath. That datapath pulses `chan_done` when a channel finishes a block of samples. The block turns each pulse into a pending status bit, if that channel's interrupt enable is set. The OR of the pending bits drives a level interrupt. The host clears a pending bit by writing that channel's interrupt enable from 1 to 0. Read data is registered. It appears on the cycle after the read strobe and holds until the next read.

Top module: `paged_audio_regs`

## Requirements
- R1: After reset, control reads 0x00000001, status reads 0x00000060, and page, codec and serial control read 0. `irq` is low and all outputs exported to the channels are 0.
- R2: Only the low 8 bits of `bus_addr` are decoded. Word reads return control at 0x00, status at 0x04, page at 0x0C, codec at 0x10 and serial control at 0x20. Read data is presented the cycle after `bus_rd` and holds until the next read.
- R3: A byte write (`bus_size`=0, data in bits 7:0) to offsets 0x00–0x03 or 0x20–0x23 replaces only the addressed byte of control or serial control. A halfword write (`bus_size`=1, data in bits 15:0) to 0x00 or 0x02 replaces the low or high half of control. A byte read at 0x00–0x03 or 0x04–0x07 returns that byte of control or status, zero-extended.
- R4: Any write to the page register at 0x0C stores only data bits 3:0. A word write (`bus_size`=2) of 0xFFFFFFA7 reads back as 7.
- R5: For offsets 0x30–0x3F only, the page value forms bits 11:8 of the effective address. The frame address and frame count registers sit at 0xC30/0xC34 for playback 1, 0xC38/0xC3C for playback 2 and 0xD30/0xD34 for record, and are written and read as words. The same offset under a different page is unmapped.
- R6: Effective addresses 0xD38 and 0xD3C read as all ones, and writes to them change no register.
- R7: Sample counts for playback 1, playback 2 and record sit at 0x24, 0x28 and 0x2C. A halfword or word write replaces only the low 16 bits. A halfword read at offset +2 returns the upper 16 bits, which this block holds at zero.
- R8: A halfword read at a frame count offset returns bits 15:0. A halfword read at that offset +2 returns bits 31:16.
- R9: A `chan_done` pulse sets the pending bit of its channel only while that channel's interrupt enable is 1. The status pending bits are bit 2 for playback 1, bit 1 for playback 2 and bit 0 for record. The enables are serial-control bit 8 for playback 1, bit 9 for playback 2 and bit 10 for record. Status bit 31 and `irq` equal the OR of the pending bits.
- R10: A serial-control write that takes a channel's interrupt enable from 1 to 0 clears that channel's pending bit. A write that leaves the enable at 1 does not clear it.
- R11: Reads of unmapped offsets, or with an unsupported access size, return 0xFFFFFFFF. A byte read at 0x1B returns 5. Writes to unmapped offsets change no register.
- R12: `chan_enable[0..2]` follow control bits 6, 5 and 4. `chan_fmt` follows serial-control bits 5:0, two bits per channel, with playback 1 lowest. `chan_inten` follows serial-control bits 10:8.
- R13: A halfword write to 0x10 stores data bits 15:0 in the codec register, and a word read there returns them zero-extended. Byte writes to 0x10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset into the window; only bits 7:0 are used |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, right-aligned for byte and halfword |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, OR of pending bits |
| chan_done | input | 3 | Block-complete pulse per channel (0 playback 1, 1 playback 2, 2 record) |
| chan_enable | output | 3 | Channel run enables |
| chan_fmt | output | 6 | Sample format per channel, two bits each |
| chan_inten | output | 3 | Channel interrupt enables |

## Verification
The bench targets the paged window. A decoder that ignored the page would return frame data under the wrong page, or let the phantom pair overwrite the record registers. It also checks that an offset arriving with high address bits set still decodes to its low byte. Partial writes are checked lane by lane, because a decoder that wrote every lane would corrupt the neighbouring bytes of control. The interrupt sequence covers several cases: a completion with its enable cleared, clears on a 1-to-0 enable change for some channels while others stay pending, and a rewrite that keeps an enable set. A design that cleared on any write, or set bits while disabled, would fail there.

// File: rtl/pac_pkg.sv
package pac_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned PAGE_W = 4;
  localparam int unsigned OFS_W  = 8;
  localparam int unsigned EFF_W  = OFS_W + PAGE_W;
  localparam int unsigned LANES  = REG_W / 8;
  localparam int unsigned CNT_W  = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam logic [EFF_W-1:0] A_CTRL    = 12'h000;
  localparam logic [EFF_W-1:0] A_STAT    = 12'h004;
  localparam logic [EFF_W-1:0] A_PAGE    = 12'h00C;
  localparam logic [EFF_W-1:0] A_CODEC   = 12'h010;
  localparam logic [EFF_W-1:0] A_LEGACY  = 12'h01B;
  localparam logic [EFF_W-1:0] A_SCTL    = 12'h020;
  localparam logic [EFF_W-1:0] A_SCNT0   = 12'h024;
  localparam logic [OFS_W-1:0] PAGED_LO  = 8'h30;
  localparam logic [OFS_W-1:0] PAGED_HI  = 8'h3F;

  localparam logic [REG_W-1:0] CTRL_RST  = 32'h0000_0001;
  localparam int unsigned      INTEN_LSB = 8;

  function automatic logic [EFF_W-1:0] frame_base(input int ch);
    case (ch)
      0:       frame_base = 12'hC30;
      1:       frame_base = 12'hC38;
      default: frame_base = 12'hD30;
    endcase
  endfunction

  function automatic logic [EFF_W-1:0] scnt_addr(input int ch);
    scnt_addr = A_SCNT0 + EFF_W'(4 * ch);
  endfunction

  typedef enum logic [3:0] {
    RS_ONES, RS_CTL, RS_CTL_B, RS_STAT, RS_STAT_B, RS_PAGE, RS_CODEC,
    RS_SCTL, RS_SCNT, RS_SCNT_HI, RS_FADDR, RS_FCNT, RS_FCNT_LO,
    RS_FCNT_HI, RS_LEGACY
  } rd_sel_e;

  typedef struct packed {
    logic [LANES-1:0]  ctl_lane;
    logic [LANES-1:0]  sctl_lane;
    logic              page;
    logic              codec;
    logic [NUM_CH-1:0] scnt;
    logic [NUM_CH-1:0] faddr;
    logic [NUM_CH-1:0] fcnt;
  } wr_sel_t;
endpackage

// File: rtl/pac_addr_decode.sv
module pac_addr_decode
  import pac_pkg::*;
(
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [1:0]        size,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  output wr_sel_t           wsel,
  output rd_sel_e           rsel,
  output logic [1:0]        rd_ch,
  output logic [1:0]        rd_lane,
  output logic [REG_W-1:0]  wdata_rep
);
  logic             paged;
  logic [EFF_W-1:0] eff;

  always_comb begin
    paged = (ofs >= PAGED_LO) && (ofs <= PAGED_HI);
    eff   = paged ? {page, ofs} : {{PAGE_W{1'b0}}, ofs};
  end

  always_comb begin
    wsel      = '0;
    rsel      = RS_ONES;
    rd_ch     = 2'd0;
    rd_lane   = eff[1:0];
    wdata_rep = wdata;
    case (size)
      SZ_BYTE: begin
        wdata_rep = {LANES{wdata[7:0]}};
        if (eff[EFF_W-1:2] == A_CTRL[EFF_W-1:2]) begin
          wsel.ctl_lane[eff[1:0]] = wr;
          rsel = RS_CTL_B;
        end
        if (eff[EFF_W-1:2] == A_SCTL[EFF_W-1:2]) wsel.sctl_lane[eff[1:0]] = wr;
        if (eff[EFF_W-1:2] == A_STAT[EFF_W-1:2]) rsel = RS_STAT_B;
        if (eff == A_PAGE) begin
          wsel.page = wr;
          rsel = RS_PAGE;
        end
        if (eff == A_LEGACY) rsel = RS_LEGACY;
      end
      SZ_HALF: begin
        wdata_rep = {2{wdata[15:0]}};
        if (eff == A_CODEC) wsel.codec = wr;
        if (eff == A_CTRL) wsel.ctl_lane = {2'b00, wr, wr};
        if (eff == A_CTRL + 12'd2) wsel.ctl_lane = {wr, wr, 2'b00};
        for (int c = 0; c < NUM_CH; c++) begin
          if (eff == scnt_addr(c)) wsel.scnt[c] = wr;
          if (eff == scnt_addr(c) + 12'd2) begin
            rsel = RS_SCNT_HI;
            rd_ch = 2'(c);
          end
          if (eff == frame_base(c) + 12'd4) begin
            rsel = RS_FCNT_LO;
            rd_ch = 2'(c);
          end
          if (eff == frame_base(c) + 12'd6) begin
            rsel = RS_FCNT_HI;
            rd_ch = 2'(c);
          end
        end
      end
      SZ_WORD: begin
        if (eff == A_CTRL) begin
          wsel.ctl_lane = {LANES{wr}};
          rsel = RS_CTL;
        end
        if (eff == A_SCTL) begin
          wsel.sctl_lane = {LANES{wr}};
          rsel = RS_SCTL;
        end
        if (eff == A_PAGE) begin
          wsel.page = wr;
          rsel = RS_PAGE;
        end
        if (eff == A_STAT) rsel = RS_STAT;
        if (eff == A_CODEC) rsel = RS_CODEC;
        for (int c = 0; c < NUM_CH; c++) begin
          if (eff == scnt_addr(c)) begin
            wsel.scnt[c] = wr;
            rsel = RS_SCNT;
            rd_ch = 2'(c);
          end
          if (eff == frame_base(c)) begin
            wsel.faddr[c] = wr;
            rsel = RS_FADDR;
            rd_ch = 2'(c);
          end
          if (eff == frame_base(c) + 12'd4) begin
            wsel.fcnt[c] = wr;
            rsel = RS_FCNT;
            rd_ch = 2'(c);
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pac_ctrl_regs.sv
module pac_ctrl_regs
  import pac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  wr_sel_t            wsel,
  input  logic [REG_W-1:0]   wdata_rep,
  input  logic [NUM_CH-1:0]  chan_done,
  output logic [REG_W-1:0]   ctl_q,
  output logic [REG_W-1:0]   sctl_q,
  output logic [PAGE_W-1:0]  page_q,
  output logic [CNT_W-1:0]   codec_q,
  output logic [NUM_CH-1:0]  pend_q,
  output logic               irq
);
  logic [REG_W-1:0]  ctl_d, sctl_d;
  logic [PAGE_W-1:0] page_d;
  logic [CNT_W-1:0]  codec_d;
  logic [NUM_CH-1:0] pend_d;
  logic              ctl_en, sctl_en, pend_en;

  always_comb begin
    ctl_d  = ctl_q;
    sctl_d = sctl_q;
    for (int k = 0; k < int'(LANES); k++) begin
      if (wsel.ctl_lane[k])  ctl_d[k*8 +: 8]  = wdata_rep[k*8 +: 8];
      if (wsel.sctl_lane[k]) sctl_d[k*8 +: 8] = wdata_rep[k*8 +: 8];
    end
    ctl_en  = |wsel.ctl_lane;
    sctl_en = |wsel.sctl_lane;
    page_d  = wdata_rep[PAGE_W-1:0];
    codec_d = wdata_rep[CNT_W-1:0];
    for (int c = 0; c < NUM_CH; c++) begin
      pend_d[c] = (pend_q[c] | (chan_done[c] & sctl_q[INTEN_LSB+c]))
                & ~(sctl_q[INTEN_LSB+c] & ~sctl_d[INTEN_LSB+c]);
    end
    pend_en = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= CTRL_RST;
      sctl_q  <= '0;
      page_q  <= '0;
      codec_q <= '0;
      pend_q  <= '0;
    end else begin
      if (ctl_en)     ctl_q   <= ctl_d;
      if (sctl_en)    sctl_q  <= sctl_d;
      if (wsel.page)  page_q  <= page_d;
      if (wsel.codec) codec_q <= codec_d;
      if (pend_en)    pend_q  <= pend_d;
    end
  end

  assign irq = |pend_q;

  for (genvar k = 0; k < int'(LANES); k++) begin : g_lane_chk
    assert_ctl_lane_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wsel.ctl_lane[k] |=> $stable(ctl_q[k*8 +: 8]));
    assert_sctl_lane_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wsel.sctl_lane[k] |=> $stable(sctl_q[k*8 +: 8]));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pend_chk
    assert_pend_needs_inten_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[c]) |-> $past(sctl_q[INTEN_LSB+c]));
    assert_inten_fall_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sctl_q[INTEN_LSB+c]) && !sctl_q[INTEN_LSB+c]) |-> !pend_q[c]);
  end
endmodule

// File: rtl/pac_chan_regs.sv
module pac_chan_regs
  import pac_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  wr_sel_t                       wsel,
  input  logic [REG_W-1:0]              wdata_rep,
  output logic [NUM_CH-1:0][CNT_W-1:0]  scnt_q,
  output logic [NUM_CH-1:0][REG_W-1:0]  faddr_q,
  output logic [NUM_CH-1:0][REG_W-1:0]  fcnt_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0] scnt_d;
    logic [REG_W-1:0] faddr_d, fcnt_d;

    always_comb begin
      scnt_d  = wdata_rep[CNT_W-1:0];
      faddr_d = wdata_rep;
      fcnt_d  = wdata_rep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scnt_q[c]  <= '0;
        faddr_q[c] <= '0;
        fcnt_q[c]  <= '0;
      end else begin
        if (wsel.scnt[c])  scnt_q[c]  <= scnt_d;
        if (wsel.faddr[c]) faddr_q[c] <= faddr_d;
        if (wsel.fcnt[c])  fcnt_q[c]  <= fcnt_d;
      end
    end

    assert_frame_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wsel.faddr[c] || wsel.fcnt[c]) |=> ($stable(faddr_q[c]) && $stable(fcnt_q[c])));
  end
endmodule

// File: rtl/paged_audio_regs.sv
module paged_audio_regs
  import pac_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic [2:0]        chan_done,
  output logic [2:0]        chan_enable,
  output logic [5:0]        chan_fmt,
  output logic [2:0]        chan_inten
);
  wr_sel_t                       wsel;
  rd_sel_e                       rsel;
  logic [1:0]                    rd_ch, rd_lane;
  logic [REG_W-1:0]              wdata_rep;
  logic [REG_W-1:0]              ctl_q, sctl_q, stat_w, rd_d, rd_q;
  logic [PAGE_W-1:0]             page_q;
  logic [CNT_W-1:0]              codec_q;
  logic [NUM_CH-1:0]             pend_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  scnt_q;
  logic [NUM_CH-1:0][REG_W-1:0]  faddr_q, fcnt_q;

  pac_addr_decode u_dec (
    .page      (page_q),
    .ofs       (bus_addr[OFS_W-1:0]),
    .size      (bus_size),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .wsel      (wsel),
    .rsel      (rsel),
    .rd_ch     (rd_ch),
    .rd_lane   (rd_lane),
    .wdata_rep (wdata_rep)
  );

  pac_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wsel      (wsel),
    .wdata_rep (wdata_rep),
    .chan_done (chan_done),
    .ctl_q     (ctl_q),
    .sctl_q    (sctl_q),
    .page_q    (page_q),
    .codec_q   (codec_q),
    .pend_q    (pend_q),
    .irq       (irq)
  );

  pac_chan_regs u_chan (
    .clk       (clk),
    .rst_n     (rst_n),
    .wsel      (wsel),
    .wdata_rep (wdata_rep),
    .scnt_q    (scnt_q),
    .faddr_q   (faddr_q),
    .fcnt_q    (fcnt_q)
  );

  always_comb begin
    stat_w = {irq, 24'h0, 2'b11, 2'b00, pend_q[0], pend_q[1], pend_q[2]};
    case (rsel)
      RS_CTL:     rd_d = ctl_q;
      RS_CTL_B:   rd_d = {24'h0, ctl_q[rd_lane*8 +: 8]};
      RS_STAT:    rd_d = stat_w;
      RS_STAT_B:  rd_d = {24'h0, stat_w[rd_lane*8 +: 8]};
      RS_PAGE:    rd_d = {{(REG_W-PAGE_W){1'b0}}, page_q};
      RS_CODEC:   rd_d = {{(REG_W-CNT_W){1'b0}}, codec_q};
      RS_SCTL:    rd_d = sctl_q;
      RS_SCNT:    rd_d = {{(REG_W-CNT_W){1'b0}}, scnt_q[rd_ch]};
      RS_SCNT_HI: rd_d = '0;
      RS_FADDR:   rd_d = faddr_q[rd_ch];
      RS_FCNT:    rd_d = fcnt_q[rd_ch];
      RS_FCNT_LO: rd_d = {16'h0, fcnt_q[rd_ch][15:0]};
      RS_FCNT_HI: rd_d = {16'h0, fcnt_q[rd_ch][31:16]};
      RS_LEGACY:  rd_d = 32'd5;
      default:    rd_d = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (bus_rd) rd_q <= rd_d;
  end

  assign bus_rdata   = rd_q;
  assign chan_enable = {ctl_q[4], ctl_q[5], ctl_q[6]};
  assign chan_fmt    = sctl_q[5:0];
  assign chan_inten  = sctl_q[INTEN_LSB +: NUM_CH];

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  assert_irq_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rsel == RS_STAT) |=> (bus_rdata[31] == $past(irq)));
endmodule

// File: tb/paged_audio_regs_test.sv
module paged_audio_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [2:0]  chan_done;
  logic [2:0]  chan_enable;
  logic [5:0]  chan_fmt;
  logic [2:0]  chan_inten;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  paged_audio_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq), .chan_done(chan_done),
    .chan_enable(chan_enable), .chan_fmt(chan_fmt), .chan_inten(chan_inten)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] exp);
    logic [31:0] d;
    rd(a, sz, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input logic [2:0] m);
    @(negedge clk);
    chan_done = m;
    @(negedge clk);
    chan_done = 3'b000;
  endtask

  task automatic t_reset;
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 enables", {29'h0, chan_enable}, 32'h0);
    check("R1 inten", {29'h0, chan_inten}, 32'h0);
    rd_chk("R1 control", 16'h00, 2, 32'h1);
    rd_chk("R1 status", 16'h04, 2, 32'h60);
    rd_chk("R1 page", 16'h0C, 2, 32'h0);
    rd_chk("R1 codec", 16'h10, 2, 32'h0);
    rd_chk("R1 sctl", 16'h20, 2, 32'h0);
  endtask

  task automatic t_lanes;
    logic [31:0] d;
    wr(16'h01, 0, 32'hFFFF_FFAB);
    rd_chk("R3 ctl byte1", 16'h00, 2, 32'h0000_AB01);
    wr(16'h03, 0, 32'h0000_005C);
    rd_chk("R3 ctl byte3", 16'h00, 2, 32'h5C00_AB01);
    wr(16'h02, 1, 32'hFFFF_1234);
    rd_chk("R3 ctl half hi", 16'h00, 2, 32'h1234_AB01);
    wr(16'h00, 1, 32'h0000_0070);
    rd(16'h00, 2, d);
    check("R3 ctl half lo", d, 32'h1234_0070);
    repeat (3) @(negedge clk);
    check("R2 rdata holds", bus_rdata, 32'h1234_0070);
    rd_chk("R3 ctl byte read", 16'h02, 0, 32'h34);
    rd_chk("R3 stat byte read", 16'h04, 0, 32'h60);
    check("R12 all enables", {29'h0, chan_enable}, 32'h7);
    wr(16'h00, 2, 32'h0000_0041);
    check("R12 play1 enable", {29'h0, chan_enable}, 32'h1);
    wr(16'h21, 0, 32'h0000_0007);
    wr(16'h20, 0, 32'h0000_001B);
    rd_chk("R3 sctl bytes", 16'h20, 2, 32'h0000_071B);
    check("R12 fmt", {26'h0, chan_fmt}, 32'h1B);
    check("R12 inten", {29'h0, chan_inten}, 32'h7);
  endtask

  task automatic t_page_paged;
    wr(16'h0C, 2, 32'hFFFF_FFA7);
    rd_chk("R4 page low bits", 16'h0C, 2, 32'h7);
    wr(16'h0C, 2, 32'hC);
    wr(16'h30, 2, 32'hDEAD_0000);
    wr(16'h34, 2, 32'h0005_0010);
    wr(16'h38, 2, 32'h1111_0000);
    wr(16'h3C, 2, 32'h0020_0030);
    rd_chk("R5 p1 faddr", 16'h30, 2, 32'hDEAD_0000);
    rd_chk("R5 p2 faddr", 16'h38, 2, 32'h1111_0000);
    rd_chk("R5 p2 fcnt", 16'h3C, 2, 32'h0020_0030);
    rd_chk("R8 fcnt lo", 16'h34, 1, 32'h0010);
    rd_chk("R8 fcnt hi", 16'h36, 1, 32'h0005);
    wr(16'h0C, 0, 32'hD);
    wr(16'h30, 2, 32'h2222_0000);
    wr(16'h34, 2, 32'h0007_0008);
    rd_chk("R5 rec faddr", 16'h30, 2, 32'h2222_0000);
    rd_chk("R2 high addr bits dropped", 16'h1234, 2, 32'h0007_0008);
    wr(16'h38, 2, 32'h0);
    wr(16'h3C, 2, 32'h0);
    rd_chk("R6 phantom addr", 16'h38, 2, 32'hFFFF_FFFF);
    rd_chk("R6 phantom cnt", 16'h3C, 2, 32'hFFFF_FFFF);
    rd_chk("R6 rec fcnt kept", 16'h34, 2, 32'h0007_0008);
    wr(16'h0C, 2, 32'h0);
    rd_chk("R5 wrong page", 16'h30, 2, 32'hFFFF_FFFF);
    wr(16'h30, 2, 32'h5);
    wr(16'h0C, 2, 32'hC);
    rd_chk("R5 wrong page write ignored", 16'h30, 2, 32'hDEAD_0000);
  endtask

  task automatic t_scount_codec;
    wr(16'h28, 2, 32'hABCD_1234);
    rd_chk("R7 word low only", 16'h28, 2, 32'h0000_1234);
    wr(16'h2C, 1, 32'h0000_9999);
    rd_chk("R7 half write", 16'h2C, 2, 32'h0000_9999);
    rd_chk("R7 upper half read", 16'h2E, 1, 32'h0);
    rd_chk("R7 p1 untouched", 16'h24, 2, 32'h0);
    wr(16'h10, 1, 32'h1234_BEEF);
    rd_chk("R13 codec", 16'h10, 2, 32'h0000_BEEF);
    wr(16'h10, 0, 32'h0);
    rd_chk("R13 byte ignored", 16'h10, 2, 32'h0000_BEEF);
  endtask

  task automatic t_irq;
    pulse(3'b001);
    check("R9 irq p1", {31'h0, irq}, 32'h1);
    rd_chk("R9 status p1", 16'h04, 2, 32'h8000_0064);
    pulse(3'b100);
    rd_chk("R9 status p1+rec", 16'h04, 2, 32'h8000_0065);
    wr(16'h20, 2, 32'h0000_061B);
    rd_chk("R10 clear p1", 16'h04, 2, 32'h8000_0061);
    check("R10 irq held", {31'h0, irq}, 32'h1);
    wr(16'h20, 2, 32'h0000_021B);
    rd_chk("R10 clear rec", 16'h04, 2, 32'h60);
    check("R9 irq low", {31'h0, irq}, 32'h0);
    pulse(3'b001);
    rd_chk("R9 disabled no set", 16'h04, 2, 32'h60);
    pulse(3'b010);
    rd_chk("R9 status p2", 16'h04, 2, 32'h8000_0062);
    wr(16'h20, 2, 32'h0000_021B);
    rd_chk("R10 stay set no clear", 16'h04, 2, 32'h8000_0062);
    wr(16'h21, 0, 32'h0);
    rd_chk("R10 byte clear p2", 16'h04, 2, 32'h60);
    check("R10 irq low", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_unmapped;
    rd_chk("R11 word 0x08", 16'h08, 2, 32'hFFFF_FFFF);
    rd_chk("R11 word 0x40", 16'h40, 2, 32'hFFFF_FFFF);
    rd_chk("R11 half codec", 16'h10, 1, 32'hFFFF_FFFF);
    rd_chk("R11 size 3", 16'h00, 3, 32'hFFFF_FFFF);
    rd_chk("R11 legacy byte", 16'h1B, 0, 32'h5);
    wr(16'h08, 2, 32'h0);
    rd_chk("R11 write ignored", 16'h00, 2, 32'h0000_0041);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_size = 2'd2; bus_wdata = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; chan_done = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lanes();
    t_page_paged();
    t_scount_codec();
    t_irq();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule